// File: doc/BRIEF.md
# Registered Bidirectional Transceiver with Parity

This block links two 8-bit buses, side A and side B, through a pair of independent holding registers. The forward register takes a byte from side A and presents it to side B. On side B a parity bit is generated from the stored byte and sent alongside it. The return register takes a byte from side B together with an incoming parity bit and presents the byte to side A. A combinational check of the stored nine bits drives an active-low error output.

Each direction has its own clock, active-low load enable, active-low output enable and status flag. A load sets the flag. The flag clears once the reader releases the output enable (a low-to-high transition). A producer can watch the flag to learn that its byte is still waiting, and a consumer can watch it to learn that fresh data is ready. This gives a simple demand-response handshake without any extra signalling.

Three-state pads are modelled as a data vector plus a drive-enable output. The bidirectional wiring is resolved outside the block. Because the data path is a plain register and not a stream, the load enable serves as the only valid qualifier. There is no ready or back-pressure: the flag is the only indication that a byte is pending, and a new load overwrites the byte held.

Top module: `xcvr_par_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, both registers read as 0x00, both flags are 0, `a_drive` and `b_drive` are 0, and `par_err_n` is 1 (the stored incoming parity bit resets to 1).
- R2: A register captures its input bus on a rising edge of its clock only when its load enable (`ld_ab_n` / `ld_ba_n`) is 0. With the load enable at 1 it holds its value, whatever its input does.
- R3: A load sets that direction's flag (`flag_ab` / `flag_ba`) at the same clock edge.
- R4: A flag clears at the first rising edge of its clock at which its output enable reads 1 after it read 0 at the previous edge, provided no load happens at that edge.
- R5: When a load and a flag-clearing enable release meet at the same clock edge, the flag is 1 after that edge.
- R6: `b_drive` is 1 exactly while `oe_b_n` is 0 and it covers both `b_out` and `b_par_out`. `a_drive` is 1 exactly while `oe_a_n` is 0. Both are 0 during reset.
- R7: `b_par_out` is the odd-parity bit of the forward register: the number of ones in `b_out` and `b_par_out` together is odd.
- R8: `b_par_in` is captured with `b_in`. `par_err_n` is 0 exactly when the number of ones in the stored byte plus the stored parity bit is even, and it changes only at a return-register load.
- R9: The two directions are independent: a load, read or flag change on one side leaves the other side's data and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Clock of the forward (A to B) register |
| ld_ab_n | input | 1 | Active-low load enable, forward register |
| a_in | input | 8 | Side A data into the forward register |
| oe_b_n | input | 1 | Active-low enable for side B data and parity drive |
| b_out | output | 8 | Forward register contents toward side B |
| b_par_out | output | 1 | Generated odd-parity bit toward side B |
| b_drive | output | 1 | Drive enable for `b_out` and `b_par_out` |
| flag_ab | output | 1 | Forward register holds unread data |
| clk_ba | input | 1 | Clock of the return (B to A) register |
| ld_ba_n | input | 1 | Active-low load enable, return register |
| b_in | input | 8 | Side B data into the return register |
| b_par_in | input | 1 | Incoming parity bit from side B |
| oe_a_n | input | 1 | Active-low enable for side A data drive |
| a_out | output | 8 | Return register contents toward side A |
| a_drive | output | 1 | Drive enable for `a_out` |
| flag_ba | output | 1 | Return register holds unread data |
| par_err_n | output | 1 | Active-low parity error on the stored return data |

## Verification
The assertions assume that load enables, output enables and data change only away from the rising edge of their own clock. They also assume that each output enable is high when reset is released, so the first sampled edge carries no false release. The bench drives every input on the falling edge of a shared 125 MHz clock and raises both enables before reset is removed, which keeps within those limits. The bench also feeds the return side deliberately corrupted parity bits, so the checks cover the error path as well as the clean one.

// File: rtl/xcvr_par_pkg.sv
package xcvr_par_pkg;
  localparam int unsigned XCVR_W = 8;

  // odd-parity helper: returns the bit that makes the total count of ones odd
  function automatic logic odd_fill(input logic [XCVR_W-1:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/xcvr_flag.sv
module xcvr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic oe_n,
  output logic flag
);
  logic oe_q;
  logic release_seen;

  assign release_seen = oe_n & ~oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b1;
      flag <= 1'b0;
    end else begin
      oe_q <= oe_n;
      if (load)              flag <= 1'b1;   // load has priority
      else if (release_seen) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/xcvr_side.sv
module xcvr_side #(
  parameter int unsigned         DW      = 8,
  parameter logic [DW-1:0]       RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic [DW-1:0] d,
  input  logic          oe_n,
  output logic [DW-1:0] q,
  output logic          flag,
  output logic          drive
);
  logic load;
  assign load = ~ld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= d;
  end

  xcvr_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .oe_n  (oe_n),
    .flag  (flag)
  );

  assign drive = rst_n & ~oe_n;
endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int unsigned W     = 8,
  parameter bit          CHECK = 1'b0
) (
  input  logic [W-1:0] d,
  input  logic         p_in,
  output logic         p_out
);
  generate
    if (CHECK) begin : g_check
      // 1 when the count of ones over data and parity is odd (good)
      assign p_out = ^{d, p_in};
    end else begin : g_gen
      logic unused_p;
      assign unused_p = p_in;
      assign p_out = ~(^d);
    end
  endgenerate
endmodule

// File: rtl/xcvr_par_top.sv
module xcvr_par_top
  import xcvr_par_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         ld_ab_n,
  input  logic [W-1:0] a_in,
  input  logic         oe_b_n,
  output logic [W-1:0] b_out,
  output logic         b_par_out,
  output logic         b_drive,
  output logic         flag_ab,
  input  logic         clk_ba,
  input  logic         ld_ba_n,
  input  logic [W-1:0] b_in,
  input  logic         b_par_in,
  input  logic         oe_a_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic         flag_ba,
  output logic         par_err_n
);
  localparam int unsigned SW = W + 1;
  localparam logic [SW-1:0] RET_RST = {1'b1, {W{1'b0}}};

  logic [SW-1:0] ret_q;

  xcvr_side #(.DW(W), .RST_VAL('0)) u_fwd (
    .clk   (clk_ab),
    .rst_n (rst_n),
    .ld_n  (ld_ab_n),
    .d     (a_in),
    .oe_n  (oe_b_n),
    .q     (b_out),
    .flag  (flag_ab),
    .drive (b_drive)
  );

  xcvr_parity #(.W(W), .CHECK(1'b0)) u_gen (
    .d     (b_out),
    .p_in  (1'b0),
    .p_out (b_par_out)
  );

  xcvr_side #(.DW(SW), .RST_VAL(RET_RST)) u_ret (
    .clk   (clk_ba),
    .rst_n (rst_n),
    .ld_n  (ld_ba_n),
    .d     ({b_par_in, b_in}),
    .oe_n  (oe_a_n),
    .q     (ret_q),
    .flag  (flag_ba),
    .drive (a_drive)
  );

  assign a_out = ret_q[W-1:0];

  xcvr_parity #(.W(W), .CHECK(1'b1)) u_chk (
    .d     (ret_q[W-1:0]),
    .p_in  (ret_q[W]),
    .p_out (par_err_n)
  );
endmodule

// File: rtl/xcvr_par_chk.sv
module xcvr_par_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         ld_ab_n,
  input logic [W-1:0] a_in,
  input logic         oe_b_n,
  input logic [W-1:0] b_out,
  input logic         b_par_out,
  input logic         b_drive,
  input logic         flag_ab,
  input logic         clk_ba,
  input logic         ld_ba_n,
  input logic [W-1:0] b_in,
  input logic         b_par_in,
  input logic         oe_a_n,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic         flag_ba,
  input logic         par_err_n
);
  // R2
  fwd_load_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !ld_ab_n |=> b_out == $past(a_in));
  // R2
  fwd_hold_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    ld_ab_n |=> $stable(b_out));
  // R2
  ret_hold_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    ld_ba_n |=> $stable(a_out));
  // R3
  fwd_flag_set_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !ld_ab_n |=> flag_ab);
  // R3
  ret_flag_set_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !ld_ba_n |=> flag_ba);
  // R4
  fwd_flag_clr_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    ($rose(oe_b_n) && ld_ab_n) |=> !flag_ab);
  // R4
  ret_flag_clr_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    ($rose(oe_a_n) && ld_ba_n) |=> !flag_ba);
  // R7
  fwd_parity_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    ^{b_out, b_par_out} == 1'b1);
  // R8
  ret_parity_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !ld_ba_n |=> par_err_n == ^{$past(b_in), $past(b_par_in)});
  // R8
  ret_err_stable_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    ld_ba_n |=> $stable(par_err_n));

  // R6
  always_comb begin
    drive_map_chk: assert (!rst_n || (b_drive == !oe_b_n && a_drive == !oe_a_n));
  end
endmodule

bind xcvr_par_top xcvr_par_chk #(.W(W)) u_xcvr_par_chk (.*);

// File: tb/tb_xcvr_par_top.sv
`timescale 1ns/1ps
module tb_xcvr_par_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ld_ab_n, oe_b_n, ld_ba_n, oe_a_n, b_par_in;
  logic [7:0] a_in, b_in;
  logic [7:0] b_out, a_out;
  logic b_par_out, b_drive, flag_ab, a_drive, flag_ba, par_err_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xcvr_par_top dut (
    .rst_n(rst_n), .clk_ab(clk), .ld_ab_n(ld_ab_n), .a_in(a_in), .oe_b_n(oe_b_n),
    .b_out(b_out), .b_par_out(b_par_out), .b_drive(b_drive), .flag_ab(flag_ab),
    .clk_ba(clk), .ld_ba_n(ld_ba_n), .b_in(b_in), .b_par_in(b_par_in), .oe_a_n(oe_a_n),
    .a_out(a_out), .a_drive(a_drive), .flag_ba(flag_ba), .par_err_n(par_err_n)
  );

  function automatic logic odd_bit(input logic [7:0] d);
    return ($countones(d) % 2) == 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic load_ab(input logic [7:0] v);
    @(negedge clk); a_in = v; ld_ab_n = 1'b0;
    @(negedge clk); ld_ab_n = 1'b1;
  endtask

  task automatic load_ba(input logic [7:0] v, input logic p);
    @(negedge clk); b_in = v; b_par_in = p; ld_ba_n = 1'b0;
    @(negedge clk); ld_ba_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ld_ab_n = 1'b1; ld_ba_n = 1'b1; oe_a_n = 1'b1; oe_b_n = 1'b1;
    a_in = 8'h00; b_in = 8'h00; b_par_in = 1'b0;
    repeat (3) @(negedge clk);
    oe_b_n = 1'b0; #1;
    chk("R1 b_drive in reset", b_drive, 0);
    oe_b_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 b_out", b_out, 8'h00);
    chk("R1 a_out", a_out, 8'h00);
    chk("R1 flags", {flag_ab, flag_ba}, 0);
    chk("R1 drives", {a_drive, b_drive}, 0);
    chk("R1 par_err_n", par_err_n, 1);
  endtask

  task automatic t_fwd_load();
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h01};
    foreach (pats[i]) begin
      load_ab(pats[i]);
      chk("R2 fwd load", b_out, pats[i]);
      chk("R3 fwd flag set", flag_ab, 1);
      chk("R7 parity gen", b_par_out, odd_bit(pats[i]));
    end
  endtask

  task automatic t_fwd_hold();
    load_ab(8'h3C);
    @(negedge clk); a_in = 8'hC3;
    repeat (2) @(negedge clk);
    chk("R2 fwd hold", b_out, 8'h3C);
    chk("R9 ret untouched by fwd", a_out, 8'h00);
    chk("R9 ret flag untouched", flag_ba, 0);
  endtask

  task automatic t_fwd_read_clear();
    @(negedge clk); oe_b_n = 1'b0; #1;
    chk("R6 b_drive on", b_drive, 1);
    chk("R6 a_drive off", a_drive, 0);
    @(negedge clk);
    chk("R4 flag held during read", flag_ab, 1);
    oe_b_n = 1'b1; #1;
    chk("R6 b_drive off", b_drive, 0);
    @(negedge clk);
    chk("R4 flag cleared after release", flag_ab, 0);
    chk("R4 data kept", b_out, 8'h3C);
  endtask

  task automatic t_collision();
    @(negedge clk); oe_b_n = 1'b0;
    @(negedge clk); oe_b_n = 1'b1; a_in = 8'h77; ld_ab_n = 1'b0;
    @(negedge clk); ld_ab_n = 1'b1;
    chk("R5 load wins over clear", flag_ab, 1);
    chk("R5 data", b_out, 8'h77);
    @(negedge clk);
    chk("R5 flag stays without new release", flag_ab, 1);
  endtask

  task automatic t_ret_parity();
    logic [7:0] v [3] = '{8'h5A, 8'h80, 8'hFE};
    foreach (v[i]) begin
      load_ba(v[i], odd_bit(v[i]));
      chk("R2 ret load", a_out, v[i]);
      chk("R3 ret flag", flag_ba, 1);
      chk("R8 good parity", par_err_n, 1);
      load_ba(v[i], ~odd_bit(v[i]));
      chk("R8 bad parity", par_err_n, 0);
    end
    @(negedge clk); b_par_in = ~b_par_in; b_in = 8'h0F;
    repeat (2) @(negedge clk);
    chk("R8 error stable without load", par_err_n, 0);
    chk("R2 ret hold", a_out, 8'hFE);
    @(negedge clk); oe_a_n = 1'b0; #1;
    chk("R6 a_drive on", a_drive, 1);
    @(negedge clk); oe_a_n = 1'b1;
    @(negedge clk);
    chk("R4 ret flag cleared", flag_ba, 0);
    chk("R9 fwd flag untouched", flag_ab, 1);
    chk("R9 fwd data untouched", b_out, 8'h77);
  endtask

  task automatic t_midrun_reset();
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async clear b_out", b_out, 0);
    chk("R1 async clear flags", {flag_ab, flag_ba}, 0);
    chk("R1 async par_err_n", par_err_n, 1);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_fwd_load();
    t_fwd_hold();
    t_fwd_read_clear();
    t_collision();
    t_ret_parity();
    t_midrun_reset();
    finish_run();
  end
endmodule